// File: doc/BRIEF.md
# Register-to-Register Logic and Shift Execute Unit

This block is the execute stage of a small register-based processor core. It takes one 20-bit instruction word per cycle. The word selects two source registers and one destination register in a 32-entry register file, and an operation. The operation is a bitwise NAND, NOR or NOT, or a logical left or right shift. The result goes back into the destination register on the same clock edge that accepts the instruction.

Instructions arrive on a valid/ready stream. The block never applies back-pressure during normal operation: `instr_ready` is low only while reset is held, and an instruction is taken on every rising edge where both `instr_valid` and `instr_ready` are high. A source that holds `instr_valid` high during reset sees no transfer until `instr_ready` rises.

An opcode outside the supported set changes no register. It raises `bad_opcode` for one cycle. A probe read port lets a test environment observe any register without disturbing execution.

Top module: `logic_shift_exec`

## Requirements
- R1: The instruction word has fixed fields: opcode in bits [19:15], first source register in [14:10], second source register in [9:5], and destination register in [4:0].
- R2: Opcode 5'b01001 writes the bitwise NAND of the two source registers to the destination.
- R3: Opcode 5'b01010 writes the bitwise NOR of the two source registers to the destination.
- R4: Opcode 5'b01011 writes the bitwise inverse of the first source register to the destination; the second source register has no effect.
- R5: Opcode 5'b01100 shifts the first source left by the value of bits [3:0] of the second source register (0 to 15 places), filling with zeros; all higher bits of the second source are ignored.
- R6: Opcode 5'b01101 shifts the first source right by bits [3:0] of the second source register, filling the vacated upper bits with zeros.
- R7: Any other opcode writes no register, and `bad_opcode` is high for exactly the one cycle after the edge that accepted it.
- R8: A synchronous active-high reset clears all 32 registers to zero and `bad_opcode` to 0, and holds `instr_ready` low.
- R9: The write lands on the edge that accepts the instruction. When the destination is also a source, the value used is the one from before that write. `probe_data` shows register `probe_addr` combinationally.
- R10: On an edge where `instr_valid` is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word present |
| instr_ready | output | 1 | Block accepts an instruction (low only in reset) |
| instr_word | input | 20 | Instruction: opcode, source1, source2, destination |
| bad_opcode | output | 1 | One-cycle pulse after an unsupported opcode is accepted |
| probe_addr | input | 5 | Register index for the probe read port |
| probe_data | output | 32 | Contents of register `probe_addr` |

## Verification
The assertions check three things on every cycle: a committed write is found at its destination on the next edge, an idle or illegal cycle leaves the addressed register unchanged, and reset leaves registers at zero. They also check that `bad_opcode` is only ever preceded by an offered instruction and that shift results carry zero fill at the vacated end. The bench scenarios alone show that each opcode gives the right value. Only they show that the high bits of the shift operand are ignored, that a register read and written by the same instruction supplies its old value, and that the illegal-opcode pulse lasts exactly one cycle. These behaviours are shown by comparing a register model against the probe port across directed sequences and a long pseudo-random stream.

// File: rtl/lse_pkg.sv
package lse_pkg;
  // Fixed instruction format; field positions are decoded behaviour.
  localparam int INSTR_W = 20;
  localparam int REG_AW  = 5;
  localparam int OPC_MSB = 19;
  localparam int OPC_LSB = 15;
  localparam int S1_LSB  = 10;
  localparam int S2_LSB  = 5;
  localparam int DST_LSB = 0;

  localparam logic [4:0] OPC_NAND = 5'b01001;
  localparam logic [4:0] OPC_NOR  = 5'b01010;
  localparam logic [4:0] OPC_INV  = 5'b01011;
  localparam logic [4:0] OPC_SHL  = 5'b01100;
  localparam logic [4:0] OPC_SHR  = 5'b01101;

  typedef enum logic [2:0] {
    ALU_NAND = 3'd0,
    ALU_NOR  = 3'd1,
    ALU_INV  = 3'd2,
    ALU_SHL  = 3'd3,
    ALU_SHR  = 3'd4
  } alu_op_e;
endpackage

// File: rtl/lse_decode.sv
module lse_decode
  import lse_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic [REG_AW-1:0]  src1,
  output logic [REG_AW-1:0]  src2,
  output logic [REG_AW-1:0]  dst,
  output alu_op_e            alu_op,
  output logic               legal
);
  logic [4:0] opc;

  assign opc  = instr[OPC_MSB:OPC_LSB];
  assign src1 = instr[S1_LSB  +: REG_AW];
  assign src2 = instr[S2_LSB  +: REG_AW];
  assign dst  = instr[DST_LSB +: REG_AW];

  always_comb begin
    legal  = 1'b1;
    alu_op = ALU_NAND;
    unique case (opc)
      OPC_NAND: alu_op = ALU_NAND;
      OPC_NOR:  alu_op = ALU_NOR;
      OPC_INV:  alu_op = ALU_INV;
      OPC_SHL:  alu_op = ALU_SHL;
      OPC_SHR:  alu_op = ALU_SHR;
      default:  legal  = 1'b0;
    endcase
  end
endmodule

// File: rtl/lse_alu.sv
module lse_alu
  import lse_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 4
) (
  input  alu_op_e           alu_op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] result
);
  localparam int STAGES = SHAMT_W;

  logic                           go_left;
  logic [DATA_W-1:0]              opa_rev;
  logic [DATA_W-1:0]              sh_in;
  logic [DATA_W-1:0]              sh_out_rev;
  logic [DATA_W-1:0]              sh_res;
  logic [STAGES:0][DATA_W-1:0]    stage;

  assign go_left = (alu_op == ALU_SHL);

  // Left shift is a right shift on the bit-reversed operand.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign opa_rev[i]    = opa[DATA_W-1-i];
    assign sh_out_rev[i] = stage[STAGES][DATA_W-1-i];
  end

  assign sh_in    = go_left ? opa_rev : opa;
  assign stage[0] = sh_in;

  // Logarithmic right shifter, one stage per distance bit, zero fill.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int DIST = 1 << s;
    assign stage[s+1] = opb[s] ? (stage[s] >> DIST) : stage[s];
  end

  assign sh_res = go_left ? sh_out_rev : stage[STAGES];

  always_comb begin
    unique case (alu_op)
      ALU_NAND: result = ~(opa & opb);
      ALU_NOR:  result = ~(opa | opb);
      ALU_INV:  result = ~opa;
      default:  result = sh_res;
    endcase
  end

  always_comb begin
    if (alu_op == ALU_SHR && opb[SHAMT_W-1:0] != '0) begin
      // R6
      shr_zero_fill_chk: assert (result[DATA_W-1] == 1'b0);
    end
    if (alu_op == ALU_SHL && opb[SHAMT_W-1:0] != '0) begin
      // R5
      shl_zero_fill_chk: assert (result[0] == 1'b0);
    end
  end
endmodule

// File: rtl/lse_regfile.sv
module lse_regfile #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  input  logic [ADDR_W-1:0] raddr_p,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b,
  output logic [DATA_W-1:0] rdata_p
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) regs[k] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  // Reads see the state before this cycle's write.
  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign rdata_p = regs[raddr_p];

  // R9
  wr_commit_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (regs[$past(waddr)] == $past(wdata)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> (regs[$past(waddr)] == $past(regs[waddr])));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (regs[raddr_p] == '0));
endmodule

// File: rtl/logic_shift_exec.sv
module logic_shift_exec
  import lse_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr_word,
  output logic               bad_opcode,
  input  logic [REG_AW-1:0]  probe_addr,
  output logic [DATA_W-1:0]  probe_data
);
  logic [REG_AW-1:0] dec_src1;
  logic [REG_AW-1:0] dec_src2;
  logic [REG_AW-1:0] dec_dst;
  alu_op_e           dec_op;
  logic              dec_legal;
  logic [DATA_W-1:0] opnd_a;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_res;
  logic              take;
  logic              rf_we;
  logic              bad_q;

  assign instr_ready = ~rst;
  assign take        = instr_valid & instr_ready;
  assign rf_we       = take & dec_legal;

  lse_decode u_decode (
    .instr  (instr_word),
    .src1   (dec_src1),
    .src2   (dec_src2),
    .dst    (dec_dst),
    .alu_op (dec_op),
    .legal  (dec_legal)
  );

  lse_regfile #(
    .DATA_W (DATA_W),
    .ADDR_W (REG_AW)
  ) u_regfile (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (dec_dst),
    .wdata   (alu_res),
    .raddr_a (dec_src1),
    .raddr_b (dec_src2),
    .raddr_p (probe_addr),
    .rdata_a (opnd_a),
    .rdata_b (opnd_b),
    .rdata_p (probe_data)
  );

  lse_alu #(
    .DATA_W  (DATA_W),
    .SHAMT_W (SHAMT_W)
  ) u_alu (
    .alu_op (dec_op),
    .opa    (opnd_a),
    .opb    (opnd_b),
    .result (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) bad_q <= 1'b0;
    else     bad_q <= take & ~dec_legal;
  end

  assign bad_opcode = bad_q;

  // R7
  bad_needs_offer_chk: assert property (@(posedge clk) disable iff (rst)
    bad_opcode |-> $past(instr_valid));

  // R7
  bad_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    bad_opcode |-> $past(!rf_we));
endmodule

// File: tb/test_logic_shift_exec.sv
module test_logic_shift_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [19:0] instr_word = '0;
  logic        bad_opcode;
  logic [4:0]  probe_addr = '0;
  logic [31:0] probe_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [31:0] model [32];

  typedef struct {
    int          due;
    logic [4:0]  addr;
    logic [31:0] data;
    logic        ill;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  logic_shift_exec i_logic_shift_exec (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .instr_word  (instr_word),
    .bad_opcode  (bad_opcode),
    .probe_addr  (probe_addr),
    .probe_data  (probe_data)
  );

  function automatic logic [31:0] ref_op(logic [4:0] opc, logic [31:0] a, logic [31:0] b);
    case (opc)
      5'b01001: return ~(a & b);
      5'b01010: return ~(a | b);
      5'b01011: return ~a;
      5'b01100: return a << b[3:0];
      5'b01101: return a >> b[3:0];
      default:  return 32'h0;
    endcase
  endfunction

  function automatic bit is_legal(logic [4:0] opc);
    return opc inside {5'b01001, 5'b01010, 5'b01011, 5'b01100, 5'b01101};
  endfunction

  function automatic string op_tag(logic [4:0] opc);
    case (opc)
      5'b01001: return "R1 R2";
      5'b01010: return "R1 R3";
      5'b01011: return "R1 R4";
      5'b01100: return "R1 R5";
      5'b01101: return "R1 R6";
      default:  return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: presents one instruction, updates the model, queues the expectation.
  task automatic issue(logic [4:0] opc, logic [4:0] s1, logic [4:0] s2,
                       logic [4:0] d, logic vld, string tag);
    item_t it;
    logic [31:0] res;
    @(negedge clk);
    instr_word  = {opc, s1, s2, d};
    instr_valid = vld;
    res = ref_op(opc, model[s1], model[s2]);
    if (vld && is_legal(opc)) model[d] = res;
    it.due  = cyc + 1;
    it.addr = d;
    it.data = model[d];
    it.ill  = vld && !is_legal(opc);
    it.tag  = tag;
    sb_q.push_back(it);
    @(posedge clk);
    #1 instr_valid = 1'b0;
  endtask

  task automatic expect_reg(logic [4:0] a, string tag);
    item_t it;
    @(negedge clk);
    it.due  = cyc + 1;
    it.addr = a;
    it.data = model[a];
    it.ill  = 1'b0;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: pops due items and compares the probe port and the flag.
  always @(negedge clk) begin
    item_t it;
    if (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      it = sb_q.pop_front();
      probe_addr = it.addr;
      #1;
      chk({it.tag, " reg"}, probe_data, it.data);
      chk({it.tag, " bad_opcode"}, {31'b0, bad_opcode}, {31'b0, it.ill});
    end
  end

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    logic [4:0]  opc;
    for (int k = 0; k < 32; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 ready low in reset", {31'b0, instr_ready}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R8 ready after reset", {31'b0, instr_ready}, 32'h1);
    chk("R8 bad_opcode after reset", {31'b0, bad_opcode}, 32'h0);
    expect_reg(5'd0,  "R8");
    expect_reg(5'd13, "R8");
    expect_reg(5'd31, "R8");

    issue(5'b01010, 5'd0, 5'd0, 5'd1, 1'b1, "R1 R3 nor");        // r1 = ffffffff
    issue(5'b01101, 5'd1, 5'd1, 5'd2, 1'b1, "R6 shr by 15");     // r2 = 0001ffff
    issue(5'b01100, 5'd1, 5'd2, 5'd3, 1'b1, "R5 shl by 15");     // r3 = ffff8000
    issue(5'b01011, 5'd3, 5'd1, 5'd4, 1'b1, "R4 not");           // r4 = 00007fff
    issue(5'b01001, 5'd2, 5'd4, 5'd5, 1'b1, "R2 nand");          // r5 = ffff8000
    issue(5'b01100, 5'd1, 5'd3, 5'd6, 1'b1, "R5 upper bits ignored"); // shift 0
    issue(5'b01101, 5'd1, 5'd4, 5'd7, 1'b1, "R6 shr 15 zero fill");
    issue(5'b01001, 5'd1, 5'd1, 5'd1, 1'b1, "R9 dst equals src");  // r1 = 0
    issue(5'b01010, 5'd1, 5'd1, 5'd1, 1'b1, "R9 dst equals src nor");
    issue(5'b00000, 5'd1, 5'd1, 5'd2, 1'b1, "R7 illegal no write");
    issue(5'b01011, 5'd2, 5'd0, 5'd8, 1'b1, "R7 pulse ends");
    issue(5'b11111, 5'd0, 5'd0, 5'd3, 1'b1, "R7 illegal all ones");
    issue(5'b01011, 5'd0, 5'd0, 5'd4, 1'b0, "R10 valid low");
    expect_reg(5'd4, "R10 hold");

    lfsr = 32'h1d2c3b4a;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[2:0])
        3'd0, 3'd5: opc = 5'b01001;
        3'd1:       opc = 5'b01010;
        3'd2:       opc = 5'b01011;
        3'd3:       opc = 5'b01100;
        3'd4:       opc = 5'b01101;
        3'd6:       opc = lfsr[7:3];
        default:    opc = 5'b01100;
      endcase
      issue(opc, lfsr[12:8], lfsr[17:13], lfsr[22:18], lfsr[31:27] != 5'd0,
            lfsr[31:27] != 5'd0 ? op_tag(opc) : "R10");
    end

    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule